// File: doc/BRIEF.md
# Edge Phase Comparator with Masked Lock Detect

This block sits in the digital part of a motor speed loop. It compares a reference clock with the frequency-generator (FG) pulse train coming back from the motor. Only the falling edge of each input takes part in the comparison. The phase error comes out as a pair of three-state pump pulses, one for "too slow" (`pump_up`) and one for "too fast" (`pump_dn`). Each pulse lasts exactly as many system clocks as the two falling edges are apart. An external loop filter integrates these pulses. When the loop is settled, the FG rate equals the reference rate one to one.

A lock detector watches the width of every comparison. A comparison narrower than the window `LOCK_WIN` counts as in phase. A pump pulse that reaches the window width counts as out of phase, and this is decided at once, without waiting for the second edge.

During pull-in the loop hunts, and the raw lock flickers on and off. A mask stage therefore holds back the active-low lock flag. The flag goes low only after the raw lock has held for `mask_len` consecutive system clocks. Any loss of lock releases the flag at once. The mask can be switched off, and the flag then follows the raw lock directly.

Both inputs are slow. The reference is at most about 10 kHz, so both inputs pass through a synchronizer and have no handshake. All pins are plain level signals: no data stream flows through this block, so there is no valid/ready interface and no back-pressure.

Top module: `phase_lock_cmp`

## Requirements
- R1: After reset, `pump_up` and `pump_dn` are 0 and `lock_n` is 1 (not locked).
- R2: When the reference falls d clocks before FG (d > 0), `pump_up` is 1 for exactly d clocks and `pump_dn` stays 0.
- R3: When FG falls d clocks before the reference (d > 0), `pump_dn` is 1 for exactly d clocks and `pump_up` stays 0.
- R4: Falling edges that arrive in the same clock produce no pump pulse. `pump_up` and `pump_dn` are never 1 together. Rising edges have no effect.
- R5: A comparison whose pulse is narrower than `LOCK_WIN` clocks sets the raw lock. A pulse that reaches `LOCK_WIN` clocks clears the raw lock while the pulse is still running. For example, a reference with no FG edges keeps `pump_up` at 1 and the block unlocked.
- R6: With `mask_en` = 0, `lock_n` is the inverse of the raw lock, with no added delay.
- R7: With `mask_en` = 1, `lock_n` falls exactly `mask_len` clocks later than it would with `mask_en` = 0. A `mask_len` of 0 gives the same timing as `mask_en` = 0.
- R8: With `mask_en` = 1, loss of raw lock raises `lock_n` in the same cycle as with masking off, and the count starts again. Lock spells shorter than `mask_len` never pull `lock_n` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Reference clock, asynchronous, falling edge used |
| fg_in | input | 1 | Motor FG signal, asynchronous, falling edge used |
| mask_en | input | 1 | 1 = apply the lock mask, 0 = pass raw lock |
| mask_len | input | MASK_W | Consecutive raw-lock clocks needed before `lock_n` falls |
| pump_up | output | 1 | Reference leads: raise motor speed |
| pump_dn | output | 1 | FG leads: lower motor speed |
| lock_n | output | 1 | Active-low lock flag |

## Verification
The bench builds the block with `LOCK_WIN` = 4, `MASK_W` = 8 and a reference period of 40 clocks. This small setting makes it cheap to sweep every edge offset from -6 to +6. That range covers both sides of the lock window, the window edge itself and coincident edges. The same small setting also lets a single lock and unlock sequence be replayed from reset for a spread of mask lengths, from 0 up to 100. The expected flag timing is simply the unmasked timing plus `mask_len`. Hunting patterns and a missing FG input also fit inside a few periods.

// File: rtl/phl_pkg.sv
package phl_pkg;
  typedef struct packed {
    logic ref_fall;
    logic fg_fall;
  } phl_edges_t;
endpackage

// File: rtl/phl_fall_det.sv
module phl_fall_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/phl_pfd.sv
module phl_pfd #(
  parameter int LOCK_WIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phl_pkg::phl_edges_t edges,
  output logic              up_q,
  output logic              dn_q,
  output logic              raw_lock
);
  localparam int CNT_W = $clog2(LOCK_WIN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   wid;
  logic             up_nx, dn_nx, done, busy;

  assign up_nx = up_q | edges.ref_fall;
  assign dn_nx = dn_q | edges.fg_fall;
  assign done  = up_nx & dn_nx;
  assign busy  = up_q | dn_q;
  assign wid   = busy ? ({1'b0, cnt_q} + 1'b1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q     <= 1'b0;
      dn_q     <= 1'b0;
      cnt_q    <= '0;
      raw_lock <= 1'b0;
    end else begin
      if (done) begin
        up_q     <= 1'b0;
        dn_q     <= 1'b0;
        cnt_q    <= '0;
        raw_lock <= (wid < (CNT_W+1)'(LOCK_WIN));
      end else begin
        up_q <= up_nx;
        dn_q <= dn_nx;
        if (busy) begin
          if (wid < (CNT_W+1)'(LOCK_WIN)) cnt_q <= cnt_q + 1'b1;
          else                            raw_lock <= 1'b0;
        end
      end
    end
  end

  assert_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({up_q, dn_q}));
  assert_up_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up_q) |-> $past(edges.ref_fall));
  assert_dn_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dn_q) |-> $past(edges.fg_fall));
  assert_wide_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wid >= (CNT_W+1)'(LOCK_WIN)) |=> !raw_lock);
endmodule

// File: rtl/phl_lock_mask.sv
module phl_lock_mask #(
  parameter int MASK_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_lock,
  input  logic [MASK_W-1:0] mask_len,
  output logic              locked
);
  logic [MASK_W-1:0] mcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mcnt_q <= '0;
    else if (!raw_lock)          mcnt_q <= '0;
    else if (mcnt_q < mask_len)  mcnt_q <= mcnt_q + 1'b1;
  end

  assign locked = raw_lock & (mcnt_q >= mask_len);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(raw_lock) |=> (mcnt_q == '0));
  assert_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && mask_len != '0) |-> $past(raw_lock));
endmodule

// File: rtl/phase_lock_cmp.sv
module phase_lock_cmp #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_WIN    = 16,
  parameter int MASK_W      = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              fg_in,
  input  logic              mask_en,
  input  logic [MASK_W-1:0] mask_len,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              lock_n
);
  localparam int NCH = 2;

  phl_pkg::phl_edges_t edges;
  logic [NCH-1:0]      raw_in, falls;
  logic                raw_lock, masked;

  assign raw_in = {ref_in, fg_in};

  for (genvar g = 0; g < NCH; g++) begin : g_det
    phl_fall_det #(.SYNC_STAGES(SYNC_STAGES)) det_i (
      .clk (clk),
      .rst_n (rst_n),
      .din (raw_in[g]),
      .fall (falls[g])
    );
  end

  assign edges.ref_fall = falls[1];
  assign edges.fg_fall  = falls[0];

  phl_pfd #(.LOCK_WIN(LOCK_WIN)) pfd_i (
    .clk (clk),
    .rst_n (rst_n),
    .edges (edges),
    .up_q (pump_up),
    .dn_q (pump_dn),
    .raw_lock (raw_lock)
  );

  phl_lock_mask #(.MASK_W(MASK_W)) mask_i (
    .clk (clk),
    .rst_n (rst_n),
    .raw_lock (raw_lock),
    .mask_len (mask_len),
    .locked (masked)
  );

  assign lock_n = ~(mask_en ? masked : raw_lock);

  assert_rst_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!pump_up && !pump_dn && lock_n));
endmodule

// File: tb/phase_lock_cmp_tb_top.sv
module phase_lock_cmp_tb_top;
  localparam int WIN = 4;
  localparam int MW  = 8;
  localparam int PER = 40;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b1, fg_in = 1'b1, mask_en = 1'b0;
  logic [MW-1:0] mask_len = '0;
  logic pump_up, pump_dn, lock_n;

  int checks = 0, errors = 0, cyc = 0;
  int fall_cyc, rise_cyc, low_cnt, both_cnt;
  logic prev_ln;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  phase_lock_cmp #(.SYNC_STAGES(2), .LOCK_WIN(WIN), .MASK_W(MW)) dut_i (
    .clk (clk), .rst_n (rst_n), .ref_in (ref_in), .fg_in (fg_in),
    .mask_en (mask_en), .mask_len (mask_len),
    .pump_up (pump_up), .pump_dn (pump_dn), .lock_n (lock_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit men, input int ml);
    rst_n = 1'b0; ref_in = 1'b1; fg_in = 1'b1;
    mask_en = men; mask_len = MW'(ml);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fall_cyc = -1; rise_cyc = -1; low_cnt = 0; both_cnt = 0; prev_ln = 1'b1;
  endtask

  task automatic run_period(input int d, output int ups, output int dns);
    ups = 0; dns = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pump_up) ups++;
      if (pump_dn) dns++;
      if (pump_up && pump_dn) both_cnt++;
      if (!lock_n) low_cnt++;
      if (lock_n !== prev_ln) begin
        if (!lock_n && fall_cyc < 0) fall_cyc = cyc;
        if (lock_n && fall_cyc >= 0 && rise_cyc < 0) rise_cyc = cyc;
      end
      prev_ln = lock_n;
      ref_in = !(i >= 10 && i < 30);
      fg_in  = !(i >= 10 + d && i < 30 + d);
    end
  endtask

  // one lock spell followed by one unlock, from reset
  task automatic lock_seq(input bit men, input int ml, output int f, output int r);
    int u, w;
    do_reset(men, ml);
    for (int k = 0; k < 6; k++) run_period(0, u, w);
    for (int k = 0; k < 2; k++) run_period(6, u, w);
    f = fall_cyc; r = rise_cyc;
  endtask

  initial begin
    #(8ns * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int u, w, t0f, t0r, tf, tr;
    int lens[5] = '{0, 1, 5, 20, 100};

    do_reset(1'b0, 0);
    @(negedge clk);
    chk(!pump_up && !pump_dn && lock_n, "R1 reset state", {pump_up, pump_dn, lock_n}, 1);

    // offset sweep, mask off
    for (int d = -6; d <= 6; d++) begin
      for (int k = 0; k < 3; k++) run_period(d, u, w);
      chk(u == (d > 0 ? d : 0), d > 0 ? "R2 up width" : "R4 up quiet", u, d > 0 ? d : 0);
      chk(w == (d < 0 ? -d : 0), d < 0 ? "R3 dn width" : "R4 dn quiet", w, d < 0 ? -d : 0);
      chk(lock_n == ((d >= WIN) || (d <= -WIN)), "R5 window lock", lock_n,
          (d >= WIN) || (d <= -WIN));
    end
    chk(both_cnt == 0, "R4 pumps exclusive", both_cnt, 0);

    // missing FG: up stuck high, unlocked
    do_reset(1'b0, 0);
    for (int k = 0; k < 3; k++) run_period(100, u, w);
    chk(u == PER, "R5 missing fg up held", u, PER);
    chk(lock_n == 1'b1, "R5 missing fg unlocked", lock_n, 1);

    // unmasked reference timing
    lock_seq(1'b0, 0, t0f, t0r);
    chk(t0f >= 0 && t0f < PER, "R6 direct lock in first period", t0f, PER / 2);
    chk(t0r >= 6 * PER && t0r < 7 * PER, "R6 direct unlock on wide pulse", t0r, 6 * PER + 16);

    // mask length sweep
    foreach (lens[j]) begin
      lock_seq(1'b1, lens[j], tf, tr);
      chk(tf == t0f + lens[j], "R7 masked lock delay", tf, t0f + lens[j]);
      chk(tr == t0r, "R8 immediate release", tr, t0r);
    end

    // hunting: lock spells shorter than the mask
    do_reset(1'b1, 60);
    for (int k = 0; k < 4; k++) begin
      run_period(0, u, w);
      run_period(6, u, w);
    end
    chk(low_cnt == 0, "R8 hunting masked", low_cnt, 0);

    do_reset(1'b0, 60);
    for (int k = 0; k < 4; k++) begin
      run_period(0, u, w);
      run_period(6, u, w);
    end
    chk(low_cnt > 0, "R6 hunting visible unmasked", low_cnt, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule